// File: doc/BRIEF.md
# Edge-Triggered Interrupt Aggregator

This block gathers a set of level status signals from neighbouring blocks, such as an audio clip-detect flag, into one interrupt line. Each status input passes through a two-stage synchroniser. The block then compares the synchronised value with the value it held one cycle earlier to find rising and falling transitions. Every source lane has its own rising-edge enable and falling-edge enable. Setting either enable, or both, lets the matching transition latch a sticky per-lane flag.

Latched flags stay visible on a flag vector until software pulses the matching bit of the clear vector. Each flag is cleared on its own. When a clear and a fresh enabled edge reach the same lane in the same cycle, the edge wins. The interrupt output is active-high and comes from a register that holds the OR of all flags, so it cannot glitch.

Top module: `irq_agg`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `flags_o` reads all zeros and `irq_o` reads 0.
- R2: A 0-to-1 change on `src_i[i]` with `rise_en_i[i]`=1 sets `flags_o[i]`. If the input changes before clock edge k, the flag reads 1 after edge k+2 (two synchroniser stages plus one flag register).
- R3: A 1-to-0 change on `src_i[i]` with `fall_en_i[i]`=1 sets `flags_o[i]` with the same latency as R2.
- R4: A lane with both enables set latches its flag on a rising change and again on a falling change.
- R5: A transition on a lane whose enable for that direction is 0 is ignored and leaves `flags_o[i]` unchanged.
- R6: A set flag stays set until a cycle with `clr_i[i]`=1. That cycle clears bit i at the next edge and leaves every other bit unchanged.
- R7: If `clr_i[i]`=1 in the same cycle that an enabled edge is detected on lane i, the flag ends up set.
- R8: `irq_o` equals the OR of `flags_o` as it stood one clock earlier.
- R9: Dropping `rise_en_i[i]` or `fall_en_i[i]` to 0 does not clear a flag that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level status inputs, one per source lane |
| rise_en_i | input | NUM_SRC | Per-lane enable for 0-to-1 transitions |
| fall_en_i | input | NUM_SRC | Per-lane enable for 1-to-0 transitions |
| clr_i | input | NUM_SRC | Per-lane clear request, acts on the next edge |
| flags_o | output | NUM_SRC | Latched per-lane interrupt flags |
| irq_o | output | 1 | Active-high interrupt, registered OR of the flags |

## Verification
The bench builds the block with its defaults: sixteen lanes and a two-stage synchroniser. At that size, lane 0 and lane 15 sit at the ends of the vector in the same run, and the exact three-edge latency from input change to flag can be checked. Directed phases give lanes different enable mixes: rise only, fall only, both, and none. They time a clear pulse to land on the same edge as a new detection. A queue-based reference model, keyed to the synchroniser depth, is compared with the flags and the interrupt on every cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Default lane count and synchroniser depth.
    localparam int IRQ_LANES_DEF = 16;
    localparam int IRQ_SYNC_DEF  = 2;

    // Transition seen on one lane during one cycle.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    // Reason the flag register of a lane takes its next value.
    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_SET   = 2'd1,
        UPD_CLEAR = 2'd2
    } flag_upd_t;

    // Build the transition pair from the current and previous sample.
    function automatic edge_pair_t classify_edge(input logic cur, input logic prev);
        edge_pair_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

    // A lane fires when a transition matches one of its enables.
    function automatic logic lane_fires(input edge_pair_t e, input logic ren, input logic fen);
        return (e.rise & ren) | (e.fall & fen);
    endfunction

    // A new edge takes priority over a clear request.
    function automatic flag_upd_t pick_update(input logic fire, input logic clr);
        flag_upd_t u;
        if (fire) begin
            u = UPD_SET;
        end else if (clr) begin
            u = UPD_CLEAR;
        end else begin
            u = UPD_HOLD;
        end
        return u;
    endfunction

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int LAST = STAGES - 1;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            logic [WIDTH-1:0] r;
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        r <= '0;
                    end else begin
                        r <= d_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        r <= '0;
                    end else begin
                        r <= g_stage[g-1].r;
                    end
                end
            end
        end
    endgenerate

    assign q_o = g_stage[LAST].r;

endmodule

// File: rtl/irq_agg_edge.sv
module irq_agg_edge
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC-1:0]       lvl_i,
    input  logic [NUM_SRC-1:0]       rise_en_i,
    input  logic [NUM_SRC-1:0]       fall_en_i,
    output edge_pair_t [NUM_SRC-1:0] edges_o,
    output logic [NUM_SRC-1:0]       fire_o
);

    logic [NUM_SRC-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= lvl_i;
        end
    end

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
            always_comb begin
                edges_o[i] = classify_edge(lvl_i[i], prev_q[i]);
                fire_o[i]  = lane_fires(edges_o[i], rise_en_i[i], fall_en_i[i]);
            end
        end
    endgenerate

endmodule

// File: rtl/irq_agg_flags.sv
module irq_agg_flags
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] fire_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] flags_o,
    output logic               irq_o
);

    flag_upd_t [NUM_SRC-1:0] upd;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
            always_comb begin
                upd[i] = pick_update(fire_i[i], clr_i[i]);
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    flags_o[i] <= 1'b0;
                end else begin
                    case (upd[i])
                        UPD_SET:   flags_o[i] <= 1'b1;
                        UPD_CLEAR: flags_o[i] <= 1'b0;
                        default:   flags_o[i] <= flags_o[i];
                    endcase
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |flags_o;
        end
    end

endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC     = IRQ_LANES_DEF,
    parameter int SYNC_STAGES = IRQ_SYNC_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] rise_en_i,
    input  logic [NUM_SRC-1:0] fall_en_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] flags_o,
    output logic               irq_o
);

    localparam int VEC_W = NUM_SRC;

    logic [VEC_W-1:0]       lvl_sync;
    edge_pair_t [VEC_W-1:0] edges;
    logic [VEC_W-1:0]       fire;

    irq_agg_sync #(
        .WIDTH  (VEC_W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (src_i),
        .q_o (lvl_sync)
    );

    irq_agg_edge #(
        .NUM_SRC (VEC_W)
    ) edge_i (
        .clk       (clk),
        .rst       (rst),
        .lvl_i     (lvl_sync),
        .rise_en_i (rise_en_i),
        .fall_en_i (fall_en_i),
        .edges_o   (edges),
        .fire_o    (fire)
    );

    irq_agg_flags #(
        .NUM_SRC (VEC_W)
    ) flags_i (
        .clk     (clk),
        .rst     (rst),
        .fire_i  (fire),
        .clr_i   (clr_i),
        .flags_o (flags_o),
        .irq_o   (irq_o)
    );

    // The transition pairs feed only the fire decision; they are kept as a
    // named net so that other logic can observe the edge direction.
    logic unused_edges;
    assign unused_edges = ^edges;

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int NUM_SRC = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] rise_en_i,
    input logic [NUM_SRC-1:0] fall_en_i,
    input logic [NUM_SRC-1:0] clr_i,
    input logic [NUM_SRC-1:0] flags_o,
    input logic               irq_o
);

    // R5: a bit can only become set if one of its enables was high
    p_set_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
        ((flags_o & ~$past(flags_o) & ~$past(rise_en_i | fall_en_i)) == '0));

    // R6: a bit can only drop when its clear was requested
    p_hold_without_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (($past(flags_o) & ~flags_o & ~$past(clr_i)) == '0));

    // R8: interrupt is the registered OR of the flags
    p_irq_follows_flags_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o == (|$past(flags_o)));

    // R9: removing every enable never clears a set bit by itself
    p_enable_drop_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(clr_i) == '0) |-> (($past(flags_o) & ~flags_o) == '0));

endmodule

bind irq_agg irq_agg_chk #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rise_en_i (rise_en_i),
    .fall_en_i (fall_en_i),
    .clr_i     (clr_i),
    .flags_o   (flags_o),
    .irq_o     (irq_o)
);

// File: tb/irq_agg_tb_top.sv
module irq_agg_tb_top;

    localparam int N   = 16;
    localparam int STG = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src = '0;
    logic [N-1:0] ren = '0;
    logic [N-1:0] fen = '0;
    logic [N-1:0] clr = '0;
    logic [N-1:0] flags;
    logic         irq;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_agg #(.NUM_SRC(N), .SYNC_STAGES(STG)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src),
        .rise_en_i (ren),
        .fall_en_i (fen),
        .clr_i     (clr),
        .flags_o   (flags),
        .irq_o     (irq)
    );

    // Behavioural reference: history of sampled inputs, sticky flags.
    logic [N-1:0] hist[$];
    logic [N-1:0] m_flag = '0;
    logic         m_irq  = 1'b0;

    always @(posedge clk) begin
        logic [N-1:0] cur, old, ev;
        if (rst) begin
            hist.delete();
            for (int k = 0; k <= STG; k++) hist.push_front('0);
            m_flag = '0;
            m_irq  = 1'b0;
            hist.push_front('0);
        end else begin
            cur = hist[STG-1];
            old = hist[STG];
            ev  = (cur & ~old & ren) | (~cur & old & fen);
            m_irq  = (m_flag != '0);
            m_flag = (m_flag & ~clr) | ev;
            hist.push_front(src);
        end
        while (hist.size() > STG + 2) void'(hist.pop_back());
    end

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Model comparison on every cycle, away from the active edge (R8 tagged).
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("model flags R6", flags, m_flag);
            check("model irq R8", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq});
        end
    end

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=5000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_neg(4);
        check("R1 flags in reset", flags, '0);
        check("R1 irq in reset", {{(N-1){1'b0}}, irq}, '0);
        rst = 1'b0;
        wait_neg(1);
        check("R1 flags after reset", flags, '0);
        check("R1 irq after reset", {{(N-1){1'b0}}, irq}, '0);

        // lane0 rise, lane1 fall, lane2 both, lane3 none, lane15 rise
        ren = 16'h8005;
        fen = 16'h0006;
        wait_neg(1);
        src = 16'h800F;
        wait_neg(2);
        check("R2 latency not yet", flags, '0);
        wait_neg(1);
        check("R2 R4 R5 rising", flags, 16'h8005);
        check("R8 irq lags flags", {{(N-1){1'b0}}, irq}, '0);
        wait_neg(1);
        check("R8 irq raised", {{(N-1){1'b0}}, irq}, 16'h0001);

        src = 16'h0000;
        wait_neg(3);
        check("R3 R4 R5 falling", flags, 16'h8007);

        clr = 16'h8001;
        wait_neg(1);
        clr = '0;
        check("R6 per-lane clear", flags, 16'h0006);
        wait_neg(3);
        check("R6 sticky", flags, 16'h0006);
        check("R8 irq held", {{(N-1){1'b0}}, irq}, 16'h0001);

        ren = '0;
        fen = '0;
        wait_neg(4);
        check("R9 enable drop keeps flags", flags, 16'h0006);

        // R7: clear lands on the same edge as a new lane4 detection
        ren = 16'h0010;
        wait_neg(1);
        src = 16'h0010;
        wait_neg(2);
        clr = 16'h0016;
        wait_neg(1);
        clr = '0;
        check("R7 edge beats clear", flags, 16'h0010);

        src = 16'h0000;   // falling on lane4, no fall enable
        wait_neg(4);
        check("R5 disabled fall ignored", flags, 16'h0010);

        clr = 16'h0010;
        wait_neg(1);
        clr = '0;
        check("R6 last clear", flags, '0);
        wait_neg(1);
        check("R8 irq drops", {{(N-1){1'b0}}, irq}, '0);

        wait_neg(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule